// File: doc/BRIEF.md
# Serial ADC conversion sequencer

This block runs an eight-input, 12-bit successive-approximation converter that is attached by four wires: a convert-start line, a serial clock, a configuration line towards the converter and a result line back from it. It derives the serial clock from the system clock with a programmable divider. It then repeats a fixed frame. In the first half of the frame the convert line is high and the serial clock is still. In the second half the convert line is low and sixteen serial clock pulses run. On those pulses the block sends a 6-bit setup word for the next conversion and reads the 12-bit result of the conversion now finishing.

The setup word for a conversion travels one frame before its result returns. For that reason every result comes out with the channel number that was requested in the frame before. The requested channel steps in ascending order through the set bits of a channel mask input, and wraps around. The input mode and polarity selections are taken in at the same moment as the channel. The first result after reset belongs to a conversion that was never configured, and it is marked as unknown.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted, the convert line, serial clock, configuration line and result strobe are all low.
- R2: A frame lasts 64*HALF_DIV system cycles. The convert line is high for the first 32*HALF_DIV cycles and the serial clock stays low during that time. The convert line is then low for 32*HALF_DIV cycles, during which the serial clock gives exactly 16 high pulses.
- R3: Each serial clock pulse is high for HALF_DIV system cycles and low for HALF_DIV system cycles.
- R4: On the first six rising serial clock edges of a frame the configuration line carries, most significant bit first, the word {single_ended, ch[0], ch[2], ch[1], unipolar, 0}. A bit changes only while the serial clock is low. The line is low on the remaining ten pulses and while the convert line is high.
- R5: The result line is sampled at the first 12 rising serial clock edges of a frame, most significant bit first. res_valid_o is high for exactly one system cycle, the cycle in which the serial clock is high for the 12th time in the frame. During that cycle res_data_o carries the 12 sampled bits.
- R6: res_chan_o equals the channel that was requested in the previous frame.
- R7: When the convert line rises, the block samples the mask and picks the next set bit above the previous request, wrapping from 7 to 0. The first frame after reset picks the lowest set bit. The mode and polarity inputs are sampled at the same moment.
- R8: When the mask is all zero, channel 0 is requested.
- R9: res_known_o is 0 with the first result after reset and 1 with every later result.
- R10: The convert line never rises again before a full frame has passed since its last rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mask_i | input | 8 | Set of active channels |
| single_ended_i | input | 1 | Mode bit placed in the setup word |
| unipolar_i | input | 1 | Polarity bit placed in the setup word |
| adc_dout_i | input | 1 | Serial result from the converter |
| adc_convst_o | output | 1 | Convert-start line |
| adc_sclk_o | output | 1 | Serial clock |
| adc_din_o | output | 1 | Serial setup word to the converter |
| res_data_o | output | 12 | Captured result |
| res_chan_o | output | 3 | Channel the result belongs to |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_known_o | output | 1 | Result came from a configured conversion |

## Verification
The assertions assume two things about the converter side: the result line changes only while the serial clock is low or just after the convert line falls, and the mask and mode inputs may change at any time except at the cycle in which the convert line rises. The bench's converter model changes the result line only on system clock falling edges that follow a serial clock fall or a convert-line fall. The bench changes the mask and mode inputs only in the middle of a frame, just after the convert line falls. Within those limits the bench sweeps about 260 mask patterns, including all-zero and all-ones, together with every combination of mode and polarity.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int unsigned NCH   = 8;
  localparam int unsigned CH_W  = 3;
  localparam int unsigned CFG_W = 6;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [CFG_W-1:0] cfg_t;

  // Setup word, MSB first: mode, ch[0], ch[2], ch[1], polarity, sleep(0)
  function automatic cfg_t build_cfg(input logic se, input chan_t ch, input logic uni);
    return {se, ch[0], ch[2], ch[1], uni, 1'b0};
  endfunction
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q;

  always_comb begin
    cnt_n = cnt_q;
    if (run_q) begin
      if (cnt_q == '0) cnt_n = CW'(HALF_DIV - 1);
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= 1'b1;
    end
  end

  assign tick_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int unsigned PER      = 16,
  parameter int unsigned HALF_DIV = 4,
  localparam int unsigned PW      = $clog2(PER)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic          conv_o,
  output logic          sclk_o,
  output logic          frame_go_o,
  output logic          nshift_o,
  output logic          nhalf_o,
  output logic [PW-1:0] nperiod_o
);
  localparam int unsigned POS_W     = PW + 2;
  localparam int unsigned FRAME_CYC = 4 * PER * HALF_DIV;
  localparam int unsigned SW        = $clog2(FRAME_CYC + 1);

  logic [POS_W-1:0] pos_q, pos_inc;
  logic             conv_q, sclk_q, conv_n, sclk_n;

  always_comb begin
    pos_inc = pos_q + 1'b1;
    conv_n  = ~pos_inc[POS_W-1];
    sclk_n  = pos_inc[POS_W-1] & pos_inc[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '1;
      conv_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (tick_i) begin
      pos_q  <= pos_inc;
      conv_q <= conv_n;
      sclk_q <= sclk_n;
    end
  end

  assign conv_o     = conv_q;
  assign sclk_o     = sclk_q;
  assign frame_go_o = tick_i && (pos_inc == '0);
  assign nshift_o   = pos_inc[POS_W-1];
  assign nhalf_o    = pos_inc[0];
  assign nperiod_o  = pos_inc[PW:1];

  // Cycles since the last convert rise, kept only for the checks below
  logic [SW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (frame_go_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != SW'(FRAME_CYC)) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_sclk_still_in_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> !sclk_o);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> (!$past(seen_q) || $past(since_q) == SW'(FRAME_CYC - 1)));
endmodule

// File: rtl/adc_chan_sel.sv
module adc_chan_sel
  import adc_ctrl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           se_i,
  input  logic           uni_i,
  output cfg_t           cfg_o,
  output chan_t          prev_ch_o,
  output logic           known_o
);
  chan_t req_q, prev_q, nxt;
  logic  se_q, uni_q, started_q, known_q, found;

  always_comb begin
    nxt   = '0;
    found = 1'b0;
    for (int j = 1; j <= NCH; j++) begin
      logic [CH_W:0] sum;
      sum = {1'b0, req_q} + (CH_W+1)'(j);
      if (!found && mask_i[sum[CH_W-1:0]]) begin
        nxt   = sum[CH_W-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= chan_t'(NCH - 1);
      prev_q    <= chan_t'(NCH - 1);
      se_q      <= 1'b0;
      uni_q     <= 1'b0;
      started_q <= 1'b0;
      known_q   <= 1'b0;
    end else if (load_i) begin
      prev_q    <= req_q;
      req_q     <= nxt;
      se_q      <= se_i;
      uni_q     <= uni_i;
      started_q <= 1'b1;
      known_q   <= started_q;
    end
  end

  assign cfg_o     = build_cfg(se_q, req_q, uni_q);
  assign prev_ch_o = prev_q;
  assign known_o   = known_q;

  // Copy of the mask seen at each load, kept only for the checks below
  logic [NCH-1:0] mask_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_seen_q <= '0;
    else if (load_i) mask_seen_q <= mask_i;
  end

  p_pick_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_i) && (mask_seen_q != '0)) |-> mask_seen_q[req_q]);

  p_empty_gives_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_i) && (mask_seen_q == '0)) |-> (req_q == '0));

  p_prev_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (prev_q == $past(req_q)));
endmodule

// File: rtl/adc_shift_io.sv
module adc_shift_io
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             nshift_i,
  input  logic             nhalf_i,
  input  logic [PW-1:0]    nperiod_i,
  input  cfg_t             cfg_i,
  input  chan_t            ch_i,
  input  logic             known_i,
  input  logic             dout_i,
  input  logic             conv_i,
  input  logic             sclk_i,
  output logic             din_o,
  output logic [RES_W-1:0] data_o,
  output chan_t            chan_o,
  output logic             valid_o,
  output logic             known_o
);
  logic [RES_W-1:0] sh_q, sh_n;
  logic [RES_W-1:0] data_q;
  chan_t            chan_q;
  logic             din_q, din_n, valid_q, known_q, cap, last;
  cfg_t             cfg_sh;

  always_comb begin
    cfg_sh = cfg_i << nperiod_i;
    din_n  = (nshift_i && (32'(nperiod_i) < CFG_W)) ? cfg_sh[CFG_W-1] : 1'b0;
    cap    = tick_i && nshift_i && nhalf_i && (32'(nperiod_i) < RES_W);
    last   = cap && (nperiod_i == PW'(RES_W - 1));
    sh_n   = {sh_q[RES_W-2:0], dout_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      if (tick_i) din_q <= din_n;
      if (cap)    sh_q  <= sh_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      chan_q  <= '0;
      known_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) begin
        data_q  <= sh_n;
        chan_q  <= ch_i;
        known_q <= known_i;
      end
    end
  end

  assign din_o   = din_q;
  assign data_o  = data_q;
  assign chan_o  = chan_q;
  assign valid_o = valid_q;
  assign known_o = known_q;

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sclk_i && !conv_i));

  p_din_quiet_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_i |-> !din_o);

  p_din_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_i |-> $stable(din_o));
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned PER      = 16,
  parameter int unsigned RES_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   chan_mask_i,
  input  logic             single_ended_i,
  input  logic             unipolar_i,
  input  logic             adc_dout_i,
  output logic             adc_convst_o,
  output logic             adc_sclk_o,
  output logic             adc_din_o,
  output logic [RES_W-1:0] res_data_o,
  output logic [CH_W-1:0]  res_chan_o,
  output logic             res_valid_o,
  output logic             res_known_o
);
  localparam int unsigned PW = $clog2(PER);

  logic          tick, frame_go, nshift, nhalf, known;
  logic [PW-1:0] nperiod;
  cfg_t          cfg;
  chan_t         prev_ch;

  adc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  adc_frame_seq #(.PER(PER), .HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .conv_o(adc_convst_o), .sclk_o(adc_sclk_o), .frame_go_o(frame_go),
    .nshift_o(nshift), .nhalf_o(nhalf), .nperiod_o(nperiod));

  adc_chan_sel u_chan (
    .clk(clk), .rst_n(rst_n), .load_i(frame_go), .mask_i(chan_mask_i),
    .se_i(single_ended_i), .uni_i(unipolar_i),
    .cfg_o(cfg), .prev_ch_o(prev_ch), .known_o(known));

  adc_shift_io #(.RES_W(RES_W), .PW(PW)) u_io (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .nshift_i(nshift),
    .nhalf_i(nhalf), .nperiod_i(nperiod), .cfg_i(cfg), .ch_i(prev_ch),
    .known_i(known), .dout_i(adc_dout_i), .conv_i(adc_convst_o),
    .sclk_i(adc_sclk_o), .din_o(adc_din_o), .data_o(res_data_o),
    .chan_o(res_chan_o), .valid_o(res_valid_o), .known_o(res_known_o));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!adc_convst_o && !adc_sclk_o && !res_valid_o));
endmodule

// File: tb/tb_adc_frame_ctrl.sv
module tb_adc_frame_ctrl;
  localparam int HD     = 4;
  localparam int FRAME  = 64 * HD;
  localparam int NFR    = 260;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mask;
  logic        se, uni, dout;
  logic        convst, sclk, din, valid, known;
  logic [11:0] data;
  logic [2:0]  chan;

  always #2 clk = ~clk;

  adc_frame_ctrl #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .chan_mask_i(mask), .single_ended_i(se),
    .unipolar_i(uni), .adc_dout_i(dout), .adc_convst_o(convst),
    .adc_sclk_o(sclk), .adc_din_o(din), .res_data_o(data),
    .res_chan_o(chan), .res_valid_o(valid), .res_known_o(known));

  int nchk = 0, nerr = 0;
  int cyc = 0, rises_seen = 0, falls_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] next_ch(input logic [2:0] cur, input logic [7:0] m);
    for (int j = 1; j <= 8; j++) begin
      logic [2:0] c;
      c = 3'((int'(cur) + j) % 8);
      if (m[c]) return c;
    end
    return 3'd0;
  endfunction

  function automatic logic [5:0] exp_word(input logic s, input logic [2:0] c, input logic u);
    return {s, c[0], c[2], c[1], u, 1'b0};
  endfunction

  // Converter model and monitors
  logic       p_conv = 0, p_sclk = 0, p_valid = 0;
  int         since = 0, hi_len = 0, sk_len = 0, rises = 0, valids = 0, bitk = 0;
  logic [5:0] word = 0, word_exp = 0;
  bit         have_word = 0;
  logic [11:0] val = 0;
  logic [2:0] exp_req = 3'd7, exp_tag = 3'd7;
  bit         exp_known = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      since++;
      if (convst) hi_len++;
      if (sclk) sk_len++;
      // frame start
      if (convst && !p_conv) begin
        if (rises_seen > 0) begin
          chk(since == FRAME, "R10 frame length", since, FRAME);
          chk(rises == 16, "R2 pulses per frame", rises, 16);
          chk(valids == 1, "R5 strobes per frame", valids, 1);
        end
        since = 0;
        exp_tag = exp_req;
        exp_known = (rises_seen > 0);
        if (have_word)
          val = 12'((int'({word[3], word[2], word[4]}) * 517) ^ (rises_seen * 37) ^ 12'h5A3);
        else
          val = 12'h000;
        have_word = 1;
        exp_req = next_ch(exp_req, mask);
        word_exp = exp_word(se, exp_req, uni);
        rises = 0;
        valids = 0;
        rises_seen++;
      end
      if (convst && sclk) chk(0, "R2 clock still in convert", 1, 0);
      if (convst && din)  chk(0, "R4 data line quiet in convert", 1, 0);
      // convert fall
      if (!convst && p_conv) begin
        chk(hi_len == 32 * HD, "R2 convert high length", hi_len, 32 * HD);
        hi_len = 0;
        bitk = 11;
        dout = val[11];
        falls_seen++;
      end
      // serial rise
      if (sclk && !p_sclk) begin
        rises++;
        if (rises <= 6) word = {word[4:0], din};
        if (rises == 6) chk(word == word_exp, "R4 R7 R8 setup word", int'(word), int'(word_exp));
        if (rises > 6 && din) chk(0, "R4 data line low after word", 1, 0);
      end
      // serial fall
      if (!sclk && p_sclk) begin
        chk(sk_len == HD, "R3 clock high length", sk_len, HD);
        sk_len = 0;
        bitk--;
        dout = (bitk >= 0) ? val[bitk] : 1'b0;
      end
      if (valid) begin
        valids++;
        chk(!p_valid, "R5 strobe width", 1, 0);
        chk(sclk && rises == 12, "R5 strobe on 12th pulse", rises, 12);
        chk(known == exp_known, "R9 known flag", known, exp_known);
        if (exp_known) begin
          chk(data == val, "R5 result data", data, val);
          chk(chan == exp_tag, "R6 result channel", chan, exp_tag);
        end
      end
      p_conv = convst;
      p_sclk = sclk;
      p_valid = valid;
      if (rises_seen > NFR) done = 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
  end

  initial begin
    rst_n = 1'b0;
    mask = 8'h05;
    se = 1'b1;
    uni = 1'b0;
    dout = 1'b0;
    repeat (3) @(negedge clk);
    chk(!convst && !sclk && !din && !valid, "R1 reset outputs",
        {convst, sclk, din, valid}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int f = 0; f < NFR; f++) begin
      wait (falls_seen > f || cyc > 150000);
      if (cyc > 150000) break;
      if (f % 50 == 7)       mask = 8'h00;
      else if (f % 50 == 8)  mask = 8'hFF;
      else if (f < 4)        mask = 8'h05;
      else                   mask = 8'((f * 29 + 3) & 255);
      se  = f[1];
      uni = f[2];
    end
    wait (done || cyc > 150000);
    if (!done) chk(0, "R2 watchdog", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule